// File: doc/BRIEF.md
# Boundary-Pausing Block DMA Engine

This engine moves a counted run of fixed-size blocks between a card-side 32-bit word stream and system memory. It uses a single running system address. Software programs a start address, a block configuration word and a block count, then pulses a start strobe. The engine then moves one 32-bit word per memory handshake. In the card-to-memory direction it takes each word from the card stream and writes it to memory. In the memory-to-card direction it reads each word from memory and hands it to the card stream.

Memory is divided into power-of-two windows, sized by a selector in the block configuration word. When the running address steps onto the start of a new window and blocks still remain, the engine stops and flags a DMA event. It waits until software writes the next system address, then carries on from that address. When the final block has moved, a separate completion flag is raised instead of the DMA flag. A data-path reset abandons whatever is in flight.

Top module: `sdma_bnd_engine`

## Requirements
- R1: After reset the engine is idle: no memory request, no card handshake, `int_status` is 0 and `blocks_left` is 0.
- R2: A start strobe is accepted only when all of the following hold: `dma_en` is 1, `cap_dma` is 1, bits 4:0 of the system address are 0, the block count is nonzero and the block byte size is nonzero. Any other start strobe is ignored and no request follows.
- R3: In card-to-memory mode (`card_to_mem`=1), each word taken from the card stream is written to memory, in order, at an address 4 above that of the previous word.
- R4: In memory-to-card mode, memory is read at successive addresses 4 apart, and each word returned is passed to the card stream in the same order.
- R5: The block byte size is `blk_cfg[11:0]` and is moved as size/4 words. `blocks_left` starts at the block count and drops by one as the last word of each block completes.
- R6: The window size is 4096 << `blk_cfg[14:12]` bytes. When a completed word leaves the address on a window multiple and blocks remain, the engine pauses, sets `int_status[3]` and issues no memory request while paused.
- R7: A system address write while idle or paused loads the address, and while paused it resumes the transfer from that address. A write while words are moving is ignored.
- R8: When the last word of the last block completes, `int_status[1]` is set and the engine returns to idle. `int_status[3]` is not set by that word, even when it ends on a window multiple.
- R9: Status bits stay set until a 1 is written to the same bit of `sts_clr`.
- R10: `dat_rst` aborts a running or paused transfer in the next cycle, clears `blocks_left` and the word position, and no further requests follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dat_rst | input | 1 | Data-path reset, aborts the transfer |
| cap_dma | input | 1 | Host supports DMA |
| dma_en | input | 1 | DMA selected for this transfer |
| xfer_start | input | 1 | Start strobe |
| card_to_mem | input | 1 | 1: card to memory, 0: memory to card |
| blk_cfg | input | 16 | [11:0] block bytes, [14:12] window selector |
| blk_cnt | input | 16 | Number of blocks |
| addr_wr | input | 1 | System address write strobe |
| addr_wdata | input | 32 | System address value |
| sts_clr | input | 16 | Write-one-to-clear status mask |
| int_status | output | 16 | Bit 1 complete, bit 3 DMA window event |
| xfer_active | output | 1 | Transfer running or paused |
| xfer_paused | output | 1 | Waiting for a new system address |
| blocks_left | output | 16 | Blocks not yet finished |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | 32 | Word address |
| mem_req_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the handshake cycle |
| card_rx_valid | input | 1 | Card word offered |
| card_rx_ready | output | 1 | Engine takes card word |
| card_rx_data | input | 32 | Card word |
| card_tx_valid | output | 1 | Word offered to card |
| card_tx_ready | input | 1 | Card takes word |
| card_tx_data | output | 32 | Word to card |

## Verification
A start strobe or a resuming address write takes effect at the next rising edge. The first handshake becomes possible one cycle later. Each memory or card handshake updates `blocks_left`, `int_status` and the pause flag at the same edge. The bench drives inputs and inspects outputs on falling edges. Memory and card handshakes are logged on the falling edge that precedes the edge where they complete. Status and counter checks are made only after the bench has seen the relevant handshake and one further falling edge has passed.

// File: rtl/sdma_bnd_pkg.sv
package sdma_bnd_pkg;
  localparam int ADDR_W     = 32;
  localparam int SEL_W      = 3;
  localparam int MIN_BND_LG = 12;
  localparam int STS_W      = 16;
  localparam int DONE_BIT   = 1;
  localparam int DMA_BIT    = 3;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SRC,
    S_MREQ,
    S_SINK,
    S_PAUSE
  } sdma_state_e;

  function automatic logic [ADDR_W-1:0] bnd_span(input logic [SEL_W-1:0] sel);
    bnd_span = ADDR_W'(1) << (MIN_BND_LG + int'(sel));
  endfunction

  function automatic logic on_bnd(input logic [ADDR_W-1:0] a,
                                  input logic [SEL_W-1:0]  sel);
    on_bnd = ((a & (bnd_span(sel) - ADDR_W'(1))) == '0);
  endfunction

  function automatic logic [ADDR_W-1:0] next_word_addr(input logic [ADDR_W-1:0] a);
    next_word_addr = a + ADDR_W'(4);
  endfunction
endpackage

// File: rtl/sdma_addr_track.sv
module sdma_addr_track
  import sdma_bnd_pkg::*;
#(
  parameter int ALIGN_LG = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step,
  input  logic [SEL_W-1:0]  bnd_sel,
  output logic [ADDR_W-1:0] addr,
  output logic              at_bnd_next,
  output logic              aligned
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_val;
    else if (step) addr <= next_word_addr(addr);
  end

  assign at_bnd_next = on_bnd(next_word_addr(addr), bnd_sel);
  assign aligned     = (addr[ALIGN_LG-1:0] == '0);

  // R3
  addr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (addr == $past(addr) + ADDR_W'(4)));
  // R7
  no_load_while_moving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !load);
endmodule

// File: rtl/sdma_block_count.sv
module sdma_block_count #(
  parameter int CW = 16,
  parameter int WW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [CW-1:0] cnt_val,
  input  logic [WW-1:0] wpb,
  input  logic          step,
  output logic [CW-1:0] blocks_left,
  output logic          last_word,
  output logic          final_word
);
  logic [WW-1:0] word_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blocks_left <= '0;
      word_idx    <= '0;
    end else if (clr) begin
      blocks_left <= '0;
      word_idx    <= '0;
    end else if (load) begin
      blocks_left <= cnt_val;
      word_idx    <= '0;
    end else if (step) begin
      if (last_word) begin
        word_idx    <= '0;
        blocks_left <= blocks_left - CW'(1);
      end else begin
        word_idx <= word_idx + WW'(1);
      end
    end
  end

  assign last_word  = (word_idx == wpb - WW'(1));
  assign final_word = last_word && (blocks_left == CW'(1));

  // R5
  block_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last_word && !clr && !load) |=> (blocks_left == $past(blocks_left) - CW'(1)));
  // R10
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (blocks_left == '0));
endmodule

// File: rtl/sdma_seq.sv
module sdma_seq
  import sdma_bnd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dat_rst,
  input  logic             go,
  input  logic             card_to_mem,
  input  logic             card_rx_valid,
  input  logic             mem_req_ready,
  input  logic             card_tx_ready,
  input  logic             addr_wr,
  input  logic             final_word,
  input  logic             at_bnd_next,
  input  logic [STS_W-1:0] sts_clr,
  output logic             card_rx_ready,
  output logic             mem_req_valid,
  output logic             mem_req_write,
  output logic             card_tx_valid,
  output logic             word_done,
  output logic             cnt_load,
  output logic             addr_load,
  output logic             rx_take,
  output logic             rd_take,
  output logic             xfer_active,
  output logic             xfer_paused,
  output logic [STS_W-1:0] int_status
);
  sdma_state_e st, st_nxt;
  logic dir_c2m;
  logic set_done, set_dma;
  sdma_state_e move_st;

  assign move_st = dir_c2m ? S_SRC : S_MREQ;

  assign card_rx_ready = (st == S_SRC);
  assign mem_req_valid = (st == S_MREQ);
  assign mem_req_write = dir_c2m;
  assign card_tx_valid = (st == S_SINK);
  assign rx_take       = card_rx_ready && card_rx_valid;
  assign rd_take       = mem_req_valid && mem_req_ready && !dir_c2m;
  assign word_done     = (mem_req_valid && mem_req_ready && dir_c2m) ||
                         (card_tx_valid && card_tx_ready);
  assign cnt_load      = go && (st == S_IDLE) && !dat_rst;
  assign addr_load     = addr_wr && ((st == S_IDLE) || (st == S_PAUSE));
  assign xfer_active   = (st != S_IDLE);
  assign xfer_paused   = (st == S_PAUSE);
  assign set_done      = word_done && final_word && !dat_rst;
  assign set_dma       = word_done && !final_word && at_bnd_next && !dat_rst;

  always_comb begin
    st_nxt = st;
    unique case (st)
      S_IDLE:  if (cnt_load) st_nxt = card_to_mem ? S_SRC : S_MREQ;
      S_SRC:   if (card_rx_valid) st_nxt = S_MREQ;
      S_MREQ:  if (mem_req_ready && !dir_c2m) st_nxt = S_SINK;
      S_SINK:  ;
      S_PAUSE: if (addr_wr) st_nxt = move_st;
      default: st_nxt = S_IDLE;
    endcase
    if (word_done) begin
      if (final_word)       st_nxt = S_IDLE;
      else if (at_bnd_next) st_nxt = S_PAUSE;
      else                  st_nxt = move_st;
    end
    if (dat_rst) st_nxt = S_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      dir_c2m    <= 1'b0;
      int_status <= '0;
    end else begin
      st <= st_nxt;
      if (cnt_load) dir_c2m <= card_to_mem;
      int_status <= (int_status & ~sts_clr)
                  | (STS_W'(set_done) << DONE_BIT)
                  | (STS_W'(set_dma)  << DMA_BIT);
    end
  end

  // R6
  bnd_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !final_word && at_bnd_next && !dat_rst) |=> (xfer_paused && int_status[DMA_BIT]));
  // R8
  final_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && final_word && !dat_rst) |=> (!xfer_active && int_status[DONE_BIT]));
  // R10
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_rst |=> !xfer_active);
  // R6
  pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_paused && !addr_wr && !dat_rst) |=> xfer_paused);
endmodule

// File: rtl/sdma_bnd_engine.sv
module sdma_bnd_engine
  import sdma_bnd_pkg::*;
#(
  parameter int CW    = 16,
  parameter int BSZ_W = 12,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dat_rst,
  input  logic              cap_dma,
  input  logic              dma_en,
  input  logic              xfer_start,
  input  logic              card_to_mem,
  input  logic [15:0]       blk_cfg,
  input  logic [CW-1:0]     blk_cnt,
  input  logic              addr_wr,
  input  logic [ADDR_W-1:0] addr_wdata,
  input  logic [STS_W-1:0]  sts_clr,
  output logic [STS_W-1:0]  int_status,
  output logic              xfer_active,
  output logic              xfer_paused,
  output logic [CW-1:0]     blocks_left,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DW-1:0]     mem_req_wdata,
  input  logic [DW-1:0]     mem_rdata,
  input  logic              card_rx_valid,
  output logic              card_rx_ready,
  input  logic [DW-1:0]     card_rx_data,
  output logic              card_tx_valid,
  input  logic              card_tx_ready,
  output logic [DW-1:0]     card_tx_data
);
  localparam int WW = BSZ_W - 2;

  logic [WW-1:0]    wpb;
  logic [SEL_W-1:0] bnd_sel;
  logic             cfg_unused;
  logic             aligned, at_bnd_next, final_word, last_word;
  logic             word_done, cnt_load, addr_load, rx_take, rd_take;
  logic             start_ok;
  logic [DW-1:0]    word_buf;

  assign wpb        = blk_cfg[BSZ_W-1:2];
  assign bnd_sel    = blk_cfg[BSZ_W+SEL_W-1:BSZ_W];
  assign cfg_unused = ^{blk_cfg[15], blk_cfg[1:0], last_word};

  assign start_ok = xfer_start && dma_en && cap_dma && aligned &&
                    (blk_cnt != '0) && (wpb != '0);

  sdma_addr_track u_addr (
    .clk         (clk),
    .rst_n       (rst_n),
    .load        (addr_load),
    .load_val    (addr_wdata),
    .step        (word_done),
    .bnd_sel     (bnd_sel),
    .addr        (mem_req_addr),
    .at_bnd_next (at_bnd_next),
    .aligned     (aligned)
  );

  sdma_block_count #(.CW(CW), .WW(WW)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (dat_rst),
    .load        (cnt_load),
    .cnt_val     (blk_cnt),
    .wpb         (wpb),
    .step        (word_done),
    .blocks_left (blocks_left),
    .last_word   (last_word),
    .final_word  (final_word)
  );

  sdma_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .dat_rst       (dat_rst),
    .go            (start_ok),
    .card_to_mem   (card_to_mem),
    .card_rx_valid (card_rx_valid),
    .mem_req_ready (mem_req_ready),
    .card_tx_ready (card_tx_ready),
    .addr_wr       (addr_wr),
    .final_word    (final_word),
    .at_bnd_next   (at_bnd_next),
    .sts_clr       (sts_clr),
    .card_rx_ready (card_rx_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_write (mem_req_write),
    .card_tx_valid (card_tx_valid),
    .word_done     (word_done),
    .cnt_load      (cnt_load),
    .addr_load     (addr_load),
    .rx_take       (rx_take),
    .rd_take       (rd_take),
    .xfer_active   (xfer_active),
    .xfer_paused   (xfer_paused),
    .int_status    (int_status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_buf <= '0;
    else if (rx_take) word_buf <= card_rx_data;
    else if (rd_take) word_buf <= mem_rdata;
  end

  assign mem_req_wdata = word_buf;
  assign card_tx_data  = word_buf;

  // R2
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_active) |-> $past(start_ok));
endmodule

// File: tb/sdma_bnd_engine_test.sv
module sdma_bnd_engine_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, dat_rst = 0, cap_dma = 1, dma_en = 1;
  logic xfer_start = 0, card_to_mem = 1, addr_wr = 0;
  logic [15:0] blk_cfg = 16'h0010, blk_cnt = 16'd1, sts_clr = 16'h0;
  logic [31:0] addr_wdata = 32'h0;
  logic [15:0] int_status, blocks_left;
  logic xfer_active, xfer_paused, mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rdata, card_rx_data, card_tx_data;
  logic card_rx_valid, card_rx_ready, card_tx_valid, card_tx_ready;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, wr_idx = 0, src_idx = 0, n_mem = 0, n_tx = 0, mism = 0;
  logic [31:0] exp_addr = 0, rd_q = 0;
  logic stall = 0, src_en = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdma_bnd_engine uut (
    .clk(clk), .rst_n(rst_n), .dat_rst(dat_rst), .cap_dma(cap_dma), .dma_en(dma_en),
    .xfer_start(xfer_start), .card_to_mem(card_to_mem), .blk_cfg(blk_cfg),
    .blk_cnt(blk_cnt), .addr_wr(addr_wr), .addr_wdata(addr_wdata), .sts_clr(sts_clr),
    .int_status(int_status), .xfer_active(xfer_active), .xfer_paused(xfer_paused),
    .blocks_left(blocks_left), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rdata(mem_rdata), .card_rx_valid(card_rx_valid), .card_rx_ready(card_rx_ready),
    .card_rx_data(card_rx_data), .card_tx_valid(card_tx_valid), .card_tx_ready(card_tx_ready),
    .card_tx_data(card_tx_data)
  );

  function automatic logic [31:0] src_word(input int i);
    return 32'hC0DE_0000 + 32'(i * 3);
  endfunction
  function automatic logic [31:0] rd_word(input logic [31:0] a);
    return a ^ 32'h5A5A_F00F;
  endfunction

  // memory and card models: handshakes logged on the falling edge before they complete
  initial begin
    mem_req_ready = 0; card_tx_ready = 0; card_rx_valid = 0;
    card_rx_data = 0; mem_rdata = 0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_req_ready = !stall || cyc[0];
      card_tx_ready = !stall || cyc[1];
      card_rx_valid = src_en && (!stall || (cyc % 3 != 0));
      card_rx_data  = src_word(src_idx);
      mem_rdata     = rd_word(mem_req_addr);
      if (mem_req_valid && mem_req_ready) begin
        n_mem++;
        if (mem_req_addr !== exp_addr) mism++;
        if (mem_req_write) begin
          if (mem_req_wdata !== src_word(wr_idx)) mism++;
          wr_idx++;
        end else begin
          rd_q = mem_req_addr;
        end
        exp_addr = exp_addr + 32'd4;
      end
      if (card_rx_valid && card_rx_ready) src_idx++;
      if (card_tx_valid && card_tx_ready) begin
        if (card_tx_data !== rd_word(rd_q)) mism++;
        n_tx++;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic arm(input logic [31:0] a);
    exp_addr = a; wr_idx = 0; src_idx = 0; n_mem = 0; n_tx = 0; mism = 0;
  endtask

  task automatic write_addr(input logic [31:0] a);
    @(negedge clk); addr_wdata = a; addr_wr = 1;
    @(negedge clk); addr_wr = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk); xfer_start = 1;
    @(negedge clk); xfer_start = 0;
  endtask

  task automatic clear_sts();
    @(negedge clk); sts_clr = 16'hFFFF;
    @(negedge clk); sts_clr = 16'h0;
  endtask

  task automatic wait_stop();
    for (int i = 0; i < 20000; i++) begin
      if (!xfer_active || xfer_paused) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic setup(input logic c2m, input logic [15:0] cfg, input logic [15:0] cnt,
                       input logic [31:0] a);
    clear_sts();
    card_to_mem = c2m; blk_cfg = cfg; blk_cnt = cnt;
    write_addr(a);
    arm(a);
  endtask

  task automatic t_reset();
    check("R1 int_status", 32'(int_status), 0);
    check("R1 active", 32'(xfer_active), 0);
    check("R1 mem_req_valid", 32'(mem_req_valid), 0);
    check("R1 card_rx_ready", 32'(card_rx_ready), 0);
    check("R1 blocks_left", 32'(blocks_left), 0);
  endtask

  task automatic t_ineligible();
    setup(1, 16'h0010, 16'd2, 32'h0000_1000);
    cap_dma = 0; pulse_start(); repeat (3) @(negedge clk);
    check("R2 no capability", 32'(xfer_active), 0);
    cap_dma = 1; dma_en = 0; pulse_start(); repeat (3) @(negedge clk);
    check("R2 dma disabled", 32'(xfer_active), 0);
    dma_en = 1; write_addr(32'h0000_1004); pulse_start(); repeat (3) @(negedge clk);
    check("R2 misaligned", 32'(xfer_active), 0);
    write_addr(32'h0000_1000); blk_cnt = 0; pulse_start(); repeat (3) @(negedge clk);
    check("R2 zero count", 32'(xfer_active), 0);
    check("R2 no requests", 32'(n_mem), 0);
  endtask

  task automatic t_c2m_basic();
    setup(1, 16'h0010, 16'd3, 32'h0000_1000);
    stall = 1;
    pulse_start();
    while (wr_idx < 2) @(negedge clk);
    write_addr(32'hDEAD_0000);
    while (wr_idx < 4) @(negedge clk);
    @(negedge clk);
    check("R5 one block done", 32'(blocks_left), 2);
    wait_stop();
    stall = 0;
    check("R3 write count", 32'(wr_idx), 12);
    check("R3 R7 addr and data order", 32'(mism), 0);
    check("R8 done status", 32'(int_status), 32'h0002);
    check("R5 blocks_left zero", 32'(blocks_left), 0);
    repeat (4) @(negedge clk);
    check("R9 done sticky", 32'(int_status), 32'h0002);
    clear_sts();
    check("R9 cleared", 32'(int_status), 0);
  endtask

  task automatic t_m2c_boundary();
    int held;
    setup(0, 16'h0010, 16'd4, 32'h0000_1FE0);
    stall = 1;
    pulse_start();
    wait_stop();
    check("R6 paused", 32'(xfer_paused), 1);
    check("R6 dma status", 32'(int_status), 32'h0008);
    check("R5 blocks at pause", 32'(blocks_left), 2);
    check("R4 words before pause", 32'(n_tx), 8);
    held = n_mem;
    repeat (12) @(negedge clk);
    check("R6 no request in pause", 32'(n_mem), 32'(held));
    check("R9 dma sticky", 32'(int_status), 32'h0008);
    clear_sts();
    @(negedge clk); addr_wdata = 32'h0000_8000; addr_wr = 1; exp_addr = 32'h0000_8000;
    @(negedge clk); addr_wr = 0;
    wait_stop();
    stall = 0;
    check("R7 resumed and finished", 32'(n_tx), 16);
    check("R4 read order and data", 32'(mism), 0);
    check("R8 done after resume", 32'(int_status), 32'h0002);
  endtask

  task automatic t_end_on_boundary();
    setup(1, 16'h0010, 16'd2, 32'h0000_2FE0);
    pulse_start();
    wait_stop();
    check("R8 no pause at end", 32'(xfer_paused), 0);
    check("R8 done only", 32'(int_status), 32'h0002);
    check("R3 writes", 32'(wr_idx), 8);
  endtask

  task automatic t_wide_window();
    setup(1, 16'h1010, 16'd4, 32'h0000_0FE0);
    pulse_start();
    wait_stop();
    check("R6 8K window no pause at 4K", 32'(int_status), 32'h0002);
    check("R6 all words", 32'(wr_idx), 16);
    check("R3 order", 32'(mism), 0);
  endtask

  task automatic t_abort();
    int held;
    setup(1, 16'h0010, 16'd10, 32'h0000_4000);
    pulse_start();
    while (wr_idx < 5) @(negedge clk);
    dat_rst = 1;
    @(negedge clk); dat_rst = 0;
    check("R10 idle", 32'(xfer_active), 0);
    check("R10 count cleared", 32'(blocks_left), 0);
    held = n_mem;
    repeat (10) @(negedge clk);
    check("R10 no more requests", 32'(n_mem), 32'(held));
    check("R10 no status", 32'(int_status), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ineligible();
    t_c2m_basic();
    t_m2c_boundary();
    t_end_on_boundary();
    t_wide_window();
    t_abort();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule